// File: doc/BRIEF.md
# Soft-Knee Decibel Gain Computer

This block turns a signal level that is already expressed in decibels into a gain-control value, also in decibels, for a dynamic range compressor. It holds a static compression curve set by five programmable values: a threshold, the reciprocal of the ratio, a knee width, the precomputed reciprocal of twice the knee width, and a make-up gain. For each accepted level x the block finds the curve output y and emits y - x + M. A downstream stage converts this control value back to the linear domain and applies it to the audio.

Every accepted sample is placed in one of three region states:

- **BELOW** is the uncompressed part of the curve.
- **KNEE** is the quadratic transition.
- **ABOVE** is the compressed part.

The stage-1 classifier makes the BELOW, KNEE or ABOVE transition fresh for each sample, from that sample's distance to the threshold. There is no history from one sample to the next. The region tag then travels with the sample through the shaping stage and the finishing stage, where a unique case on the tag selects the result. A region-dependent divide is not needed: the ratio arrives as its reciprocal, and the knee uses a precomputed 1/(2W).

Numbers use these formats:

- Levels, the threshold, the knee width and the gain are raw Q8.8. The level, threshold and gain are signed; the knee width is unsigned.
- The reciprocal ratio is unsigned Q1.15, so 0x8000 means 1:1.
- The knee reciprocal is unsigned Q2.14.
- In the formulas below, d = x - T in raw units, and ">>> n" is a floor (arithmetic) shift.

Top module: `soft_knee_gain`

## Requirements
- R1: While reset is low, out_valid is 0 and out_gain is 0. After reset the configuration is T=0, invR=0x8000, W=0, 1/(2W)=0 and M=0, so any sample then yields gain 0.
- R2: Each cycle with in_valid high produces exactly one cycle of out_valid high. That result appears after the third rising edge, counting the edge that captures the input. Samples may arrive on consecutive cycles.
- R3: BELOW region: 2d < -W, or d <= 0 when W = 0. The gain is M.
- R4: ABOVE region: 2d > W, or d > 0 when W = 0. The gain is T + ((d*invR) >>> 15) - x + M.
- R5: KNEE region: -W <= 2d <= W with W > 0, both bounds inclusive. Let s = 2d + W and V = (s*s*kinv) >>> 24. The gain is (((invR - 32768)*V) >>> 15) + M.
- R6: When W = 0 the curve is a hard knee at T. A level exactly equal to T gives gain M, and a level one LSB above T follows R4.
- R7: A gain outside the signed 16-bit range saturates: to 0x7FFF when positive, to 0x8000 when negative.
- R8: While out_valid is low, out_gain keeps the last value produced.
- R9: cfg_we high at a rising edge loads all five configuration fields together. A sample captured on any later edge uses the new values.
- R10: With invR <= 0x8000 and M = 0, the gain is never positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_thresh | input | 16 | Threshold T, signed Q8.8 dB |
| cfg_inv_ratio | input | 16 | 1/R, unsigned Q1.15 |
| cfg_knee | input | 16 | Knee width W, unsigned Q8.8 dB |
| cfg_knee_inv | input | 16 | 1/(2W), unsigned Q2.14 |
| cfg_makeup | input | 16 | Make-up gain M, signed Q8.8 dB |
| in_valid | input | 1 | Input level strobe |
| in_db | input | 16 | Input level, signed Q8.8 dB |
| out_valid | output | 1 | Gain result strobe |
| out_gain | output | 16 | Control gain, signed Q8.8 dB |

## Verification
The region tag and the intermediate products are held in pipeline registers. An error in any of them reaches out_gain three edges after the affected sample is captured, and it is visible only on that sample's strobe. A misclassified region therefore shows up as a make-up-only gain where a slope was expected, or the other way round. It is most easily seen at the inclusive knee bounds and at exactly T with a zero knee. A lost or duplicated valid bit shows up as a strobe that is early, late, missing or extra relative to the input stream. A stale configuration shows up on the first sample that is captured after a write.

// File: rtl/soft_knee_gain_pkg.sv
`timescale 1ns/1ps
package soft_knee_gain_pkg;

    localparam int DB_W       = 16;
    localparam int DB_FRAC    = 8;
    localparam int RATIO_W    = 16;
    localparam int RATIO_FRAC = 15;
    localparam int KINV_W     = 16;
    localparam int KINV_FRAC  = 14;

    typedef enum logic [1:0] {
        RG_BELOW = 2'd0,
        RG_KNEE  = 2'd1,
        RG_ABOVE = 2'd2
    } region_e;

endpackage

// File: rtl/gc_cfg_regs.sv
`timescale 1ns/1ps
module gc_cfg_regs #(
    parameter int DB_W       = 16,
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 15,
    parameter int KINV_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic signed [DB_W-1:0]    cfg_thresh,
    input  logic [RATIO_W-1:0]        cfg_inv_ratio,
    input  logic [DB_W-1:0]           cfg_knee,
    input  logic [KINV_W-1:0]         cfg_knee_inv,
    input  logic signed [DB_W-1:0]    cfg_makeup,
    output logic signed [DB_W-1:0]    thr_q,
    output logic [RATIO_W-1:0]        ratio_q,
    output logic [DB_W-1:0]           knee_q,
    output logic [KINV_W-1:0]         kinv_q,
    output logic signed [DB_W-1:0]    makeup_q
);

    localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1) << RATIO_FRAC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q    <= '0;
            ratio_q  <= RATIO_ONE;
            knee_q   <= '0;
            kinv_q   <= '0;
            makeup_q <= '0;
        end else if (cfg_we) begin
            thr_q    <= cfg_thresh;
            ratio_q  <= cfg_inv_ratio;
            knee_q   <= cfg_knee;
            kinv_q   <= cfg_knee_inv;
            makeup_q <= cfg_makeup;
        end
    end

endmodule

// File: rtl/gc_classify.sv
`timescale 1ns/1ps
module gc_classify
    import soft_knee_gain_pkg::*;
#(
    parameter int DB_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [DB_W-1:0]  in_db,
    input  logic signed [DB_W-1:0]  thresh,
    input  logic [DB_W-1:0]         knee,
    output logic                    s1_valid,
    output region_e                 s1_region,
    output logic signed [DB_W:0]    s1_diff,
    output logic signed [DB_W+2:0]  s1_span,
    output logic signed [DB_W-1:0]  s1_x
);

    localparam int DW = DB_W + 1;
    localparam int SW = DB_W + 3;

    logic signed [DW-1:0] diff;
    logic signed [SW-1:0] twice;
    logic signed [SW-1:0] kw;
    logic signed [SW-1:0] span;
    region_e              region_nx;

    // next-state decision: which curve region this sample enters
    always_comb begin
        diff  = DW'(in_db) - DW'(thresh);
        twice = SW'(diff) <<< 1;
        kw    = {{(SW-DB_W){1'b0}}, knee};
        span  = twice + kw;
        if (knee == '0) begin
            region_nx = (diff > 0) ? RG_ABOVE : RG_BELOW;
        end else if (twice < -kw) begin
            region_nx = RG_BELOW;
        end else if (twice > kw) begin
            region_nx = RG_ABOVE;
        end else begin
            region_nx = RG_KNEE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_region <= RG_BELOW;
            s1_diff   <= '0;
            s1_span   <= '0;
            s1_x      <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_region <= region_nx;
                s1_diff   <= diff;
                s1_span   <= span;
                s1_x      <= in_db;
            end
        end
    end

endmodule

// File: rtl/gc_shape.sv
`timescale 1ns/1ps
module gc_shape
    import soft_knee_gain_pkg::*;
#(
    parameter int DB_W       = 16,
    parameter int DB_FRAC    = 8,
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 15,
    parameter int KINV_W     = 16,
    parameter int KINV_FRAC  = 14,
    parameter int AW         = DB_W + 6,
    parameter int VW         = 2 * (DB_W + 3) + KINV_W + 1 - (DB_FRAC + KINV_FRAC + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  region_e                 s1_region,
    input  logic signed [DB_W:0]    s1_diff,
    input  logic signed [DB_W+2:0]  s1_span,
    input  logic signed [DB_W-1:0]  s1_x,
    input  logic signed [DB_W-1:0]  thresh,
    input  logic [RATIO_W-1:0]      inv_ratio,
    input  logic [KINV_W-1:0]       knee_inv,
    output logic                    s2_valid,
    output region_e                 s2_region,
    output logic signed [AW-1:0]    s2_above,
    output logic signed [VW-1:0]    s2_bend
);

    localparam int DW  = DB_W + 1;
    localparam int SW  = DB_W + 3;
    localparam int PW  = DW + RATIO_W + 1;
    localparam int QW  = 2 * SW;
    localparam int KW  = QW + KINV_W + 1;
    // square of (2e) carries 2*DB_FRAC fraction bits and a factor 4
    localparam int KSH = 2 * DB_FRAC + KINV_FRAC - DB_FRAC + 2;

    logic signed [PW-1:0] slope;
    logic signed [AW-1:0] above;
    logic signed [QW-1:0] sq;
    logic signed [KW-1:0] kp;
    logic signed [VW-1:0] bend;

    always_comb begin
        slope = PW'(s1_diff) * PW'($signed({1'b0, inv_ratio}));
        above = AW'(slope >>> RATIO_FRAC) + AW'(thresh) - AW'(s1_x);
        sq    = QW'(s1_span) * QW'(s1_span);
        kp    = KW'(sq) * KW'($signed({1'b0, knee_inv}));
        bend  = VW'(kp >>> KSH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_region <= RG_BELOW;
            s2_above  <= '0;
            s2_bend   <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_region <= s1_region;
                s2_above  <= above;
                s2_bend   <= bend;
            end
        end
    end

endmodule

// File: rtl/gc_finish.sv
`timescale 1ns/1ps
module gc_finish
    import soft_knee_gain_pkg::*;
#(
    parameter int DB_W       = 16,
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 15,
    parameter int AW         = DB_W + 6,
    parameter int VW         = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s2_valid,
    input  region_e                 s2_region,
    input  logic signed [AW-1:0]    s2_above,
    input  logic signed [VW-1:0]    s2_bend,
    input  logic [RATIO_W-1:0]      inv_ratio,
    input  logic signed [DB_W-1:0]  makeup,
    output logic                    out_valid,
    output logic signed [DB_W-1:0]  out_gain
);

    localparam int CW = RATIO_W + 1;
    localparam int BW = CW + VW;
    localparam int GW = (BW > AW + 2) ? BW : AW + 2;
    localparam logic signed [CW-1:0] UNITY = CW'(longint'(1) <<< RATIO_FRAC);
    localparam logic signed [GW-1:0] G_MAX = GW'((longint'(1) <<< (DB_W - 1)) - 1);
    localparam logic signed [GW-1:0] G_MIN = -G_MAX - GW'(1);

    logic signed [CW-1:0] coef;
    logic signed [BW-1:0] bend_prod;
    logic signed [GW-1:0] g_raw;
    logic signed [GW-1:0] g_sat;

    // output decision per region state
    always_comb begin
        coef      = CW'($signed({1'b0, inv_ratio})) - UNITY;
        bend_prod = BW'(coef) * BW'(s2_bend);
        unique case (s2_region)
            RG_BELOW: g_raw = GW'(makeup);
            RG_ABOVE: g_raw = GW'(s2_above) + GW'(makeup);
            RG_KNEE:  g_raw = GW'(bend_prod >>> RATIO_FRAC) + GW'(makeup);
            default:  g_raw = GW'(makeup);
        endcase
        if (g_raw > G_MAX) begin
            g_sat = G_MAX;
        end else if (g_raw < G_MIN) begin
            g_sat = G_MIN;
        end else begin
            g_sat = g_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_gain  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_gain <= DB_W'(g_sat);
            end
        end
    end

endmodule

// File: rtl/soft_knee_gain.sv
`timescale 1ns/1ps
module soft_knee_gain
    import soft_knee_gain_pkg::*;
#(
    parameter int DB_W       = soft_knee_gain_pkg::DB_W,
    parameter int DB_FRAC    = soft_knee_gain_pkg::DB_FRAC,
    parameter int RATIO_W    = soft_knee_gain_pkg::RATIO_W,
    parameter int RATIO_FRAC = soft_knee_gain_pkg::RATIO_FRAC,
    parameter int KINV_W     = soft_knee_gain_pkg::KINV_W,
    parameter int KINV_FRAC  = soft_knee_gain_pkg::KINV_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic signed [DB_W-1:0]  cfg_thresh,
    input  logic [RATIO_W-1:0]      cfg_inv_ratio,
    input  logic [DB_W-1:0]         cfg_knee,
    input  logic [KINV_W-1:0]       cfg_knee_inv,
    input  logic signed [DB_W-1:0]  cfg_makeup,
    input  logic                    in_valid,
    input  logic signed [DB_W-1:0]  in_db,
    output logic                    out_valid,
    output logic signed [DB_W-1:0]  out_gain
);

    localparam int AW = DB_W + 6;
    localparam int VW = 2 * (DB_W + 3) + KINV_W + 1 - (DB_FRAC + KINV_FRAC + 2);

    logic signed [DB_W-1:0] thr_q;
    logic [RATIO_W-1:0]     ratio_q;
    logic [DB_W-1:0]        knee_q;
    logic [KINV_W-1:0]      kinv_q;
    logic signed [DB_W-1:0] makeup_q;

    logic                   s1_valid;
    region_e                s1_region;
    logic signed [DB_W:0]   s1_diff;
    logic signed [DB_W+2:0] s1_span;
    logic signed [DB_W-1:0] s1_x;

    logic                   s2_valid;
    region_e                s2_region;
    logic signed [AW-1:0]   s2_above;
    logic signed [VW-1:0]   s2_bend;

    gc_cfg_regs #(
        .DB_W(DB_W), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC), .KINV_W(KINV_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_thresh(cfg_thresh), .cfg_inv_ratio(cfg_inv_ratio),
        .cfg_knee(cfg_knee), .cfg_knee_inv(cfg_knee_inv), .cfg_makeup(cfg_makeup),
        .thr_q(thr_q), .ratio_q(ratio_q), .knee_q(knee_q),
        .kinv_q(kinv_q), .makeup_q(makeup_q)
    );

    gc_classify #(.DB_W(DB_W)) u_class (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_db(in_db),
        .thresh(thr_q), .knee(knee_q),
        .s1_valid(s1_valid), .s1_region(s1_region), .s1_diff(s1_diff),
        .s1_span(s1_span), .s1_x(s1_x)
    );

    gc_shape #(
        .DB_W(DB_W), .DB_FRAC(DB_FRAC), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC),
        .KINV_W(KINV_W), .KINV_FRAC(KINV_FRAC), .AW(AW), .VW(VW)
    ) u_shape (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_region(s1_region), .s1_diff(s1_diff),
        .s1_span(s1_span), .s1_x(s1_x),
        .thresh(thr_q), .inv_ratio(ratio_q), .knee_inv(kinv_q),
        .s2_valid(s2_valid), .s2_region(s2_region),
        .s2_above(s2_above), .s2_bend(s2_bend)
    );

    gc_finish #(
        .DB_W(DB_W), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC), .AW(AW), .VW(VW)
    ) u_finish (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_region(s2_region),
        .s2_above(s2_above), .s2_bend(s2_bend),
        .inv_ratio(ratio_q), .makeup(makeup_q),
        .out_valid(out_valid), .out_gain(out_gain)
    );

endmodule

// File: rtl/soft_knee_gain_chk.sv
`timescale 1ns/1ps
module soft_knee_gain_chk #(
    parameter int DB_W       = 16,
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    in_valid,
    input  logic signed [DB_W-1:0]  in_db,
    input  logic                    out_valid,
    input  logic signed [DB_W-1:0]  out_gain,
    input  logic signed [DB_W-1:0]  thr_q,
    input  logic [RATIO_W-1:0]      ratio_q,
    input  logic [DB_W-1:0]         knee_q,
    input  logic signed [DB_W-1:0]  makeup_q
);

    localparam logic [RATIO_W:0] RATIO_ONE = (RATIO_W+1)'(1) << RATIO_FRAC;

    logic [2:0]             vhist;
    logic signed [DB_W-1:0] xh0, xh1, xh2;
    logic [2:0]             quiet_cnt;
    logic                   quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vhist     <= '0;
            xh0       <= '0;
            xh1       <= '0;
            xh2       <= '0;
            quiet_cnt <= '0;
        end else begin
            vhist <= {vhist[1:0], in_valid};
            xh0   <= in_db;
            xh1   <= xh0;
            xh2   <= xh1;
            if (cfg_we) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt < 3'd4) begin
                quiet_cnt <= quiet_cnt + 3'd1;
            end
        end
    end

    assign quiet = (quiet_cnt >= 3'd4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!out_valid && out_gain == '0); // R1
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[2]); // R2

    AST_BELOW_MAKEUP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && quiet && knee_q == '0 && xh2 <= thr_q) |-> (out_gain == makeup_q)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vhist[1] |=> $stable(out_gain)); // R8

    AST_NO_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && quiet && makeup_q == '0 && {1'b0, ratio_q} <= RATIO_ONE) |-> (out_gain <= 0)); // R10

endmodule

bind soft_knee_gain soft_knee_gain_chk #(
    .DB_W(DB_W), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .in_valid(in_valid), .in_db(in_db),
    .out_valid(out_valid), .out_gain(out_gain),
    .thr_q(thr_q), .ratio_q(ratio_q), .knee_q(knee_q), .makeup_q(makeup_q)
);

// File: tb/soft_knee_gain_test.sv
`timescale 1ns/1ps
module soft_knee_gain_test;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cfg_we = 1'b0;
    logic signed [15:0] cfg_thresh = '0;
    logic [15:0]        cfg_inv_ratio = '0;
    logic [15:0]        cfg_knee = '0;
    logic [15:0]        cfg_knee_inv = '0;
    logic signed [15:0] cfg_makeup = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_db = '0;
    logic               out_valid;
    logic signed [15:0] out_gain;

    soft_knee_gain uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_thresh(cfg_thresh), .cfg_inv_ratio(cfg_inv_ratio),
        .cfg_knee(cfg_knee), .cfg_knee_inv(cfg_knee_inv), .cfg_makeup(cfg_makeup),
        .in_valid(in_valid), .in_db(in_db),
        .out_valid(out_valid), .out_gain(out_gain)
    );

    always #2.5 clk = ~clk;

    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    bit     finished = 0;
    bit     have_last = 0;
    int     last_out = 0;

    int     b_t = 0, b_ir = 32768, b_w = 0, b_iw = 0, b_m = 0;

    int     exp_q[$];
    longint stamp_q[$];
    string  tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model(input int x, output string tag);
        longint d, tw, s, v, g;
        d  = longint'(x) - b_t;
        tw = 2 * d;
        if (b_w == 0) begin
            if (d > 0) begin
                g = b_t + ((d * b_ir) >>> 15) - x + b_m; tag = "R6/R4";
            end else begin
                g = b_m; tag = "R6/R3";
            end
        end else if (tw < -b_w) begin
            g = b_m; tag = "R3";
        end else if (tw > b_w) begin
            g = b_t + ((d * b_ir) >>> 15) - x + b_m; tag = "R4";
        end else begin
            s = tw + b_w;
            v = (s * s * b_iw) >>> 24;
            g = (((longint'(b_ir) - 32768) * v) >>> 15) + b_m; tag = "R5";
        end
        if (g > 32767) begin g = 32767; tag = "R7"; end
        if (g < -32768) begin g = -32768; tag = "R7"; end
        return int'(g);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic observe();
        int     e;
        longint st;
        string  tg;
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected strobe", 1, 0);
            end else begin
                e = exp_q.pop_front(); st = stamp_q.pop_front(); tg = tag_q.pop_front();
                check("R2 latency", int'(cyc - st), 3);
                check(tg, int'(out_gain), e);
                last_out = int'(out_gain); have_last = 1;
            end
        end else if (have_last) begin
            if (int'(out_gain) != last_out) check("R8 hold", int'(out_gain), last_out);
        end
    endtask

    task automatic drive(input bit v, input int x, input string force_tag);
        string tg;
        int    e;
        @(negedge clk);
        observe();
        in_valid = v;
        in_db    = 16'(x);
        if (v) begin
            e = model(x, tg);
            if (force_tag != "") tg = force_tag;
            exp_q.push_back(e); stamp_q.push_back(cyc); tag_q.push_back(tg);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) drive(0, 0, "");
    endtask

    task automatic config_set(input int t, input int ir, input int w, input int iw, input int m);
        @(negedge clk);
        observe();
        in_valid = 0;
        cfg_we = 1; cfg_thresh = 16'(t); cfg_inv_ratio = 16'(ir);
        cfg_knee = 16'(w); cfg_knee_inv = 16'(iw); cfg_makeup = 16'(m);
        b_t = t; b_ir = ir; b_w = w; b_iw = iw; b_m = m;
        @(negedge clk);
        observe();
        cfg_we = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset gain", int'(out_gain), 0);
        rst_n = 1'b1;

        // defaults give unity gain
        drive(1, 16'sh1000, "R1");
        drive(1, -16'sd5000, "R1");
        drain();

        // hard knee at -20 dB, 4:1
        config_set(-5120, 16'h2000, 0, 0, 0);
        drive(1, -7680, "R3");
        drive(1, -5120, "R6");
        drive(1, -5119, "R6");
        drive(1, 0, "R4");
        drain();

        // soft knee 6 dB wide, make-up 3 dB, boundaries inclusive
        config_set(-5120, 16'h2000, 1536, 2097152 / 1536, 768);
        drive(1, -5120 - 768, "R5");
        drive(1, -5120 - 769, "R3");
        drive(1, -5120, "R5");
        drive(1, -5120 + 768, "R5");
        drive(1, -5120 + 769, "R4");
        drain();

        // saturation both ways
        config_set(-32768, 0, 0, 0, 0);
        drive(1, 32767, "R7");
        drain();
        config_set(-32768, 16'hFFFF, 0, 0, 0);
        drive(1, 32767, "R7");
        drain();
        config_set(0, 16'h8000, 0, 0, 32767);
        drive(1, -100, "R3");
        drain();

        // a write takes effect on the very next captured sample
        config_set(0, 16'h4000, 0, 0, -256);
        drive(1, 2560, "R9");
        drive(1, -2560, "R9");
        drain();

        // random configurations with bursty stimulus
        for (int c = 0; c < 16; c++) begin
            int t, ir, w, iw, m;
            t  = -int'($urandom_range(15360, 0));
            ir = int'($urandom_range(65535, 0));
            w  = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(6144, 64));
            iw = (w == 0) ? 0 : 2097152 / w;
            if (iw > 65535) iw = 65535;
            m  = int'($urandom_range(9216, 0)) - 3072;
            config_set(t, ir, w, iw, m);
            for (int k = 0; k < 40; k++) begin
                logic signed [15:0] r;
                r = 16'($urandom);
                if ($urandom_range(3, 0) == 0) r = 16'(t + int'($urandom_range(2 * w + 8, 0)) - w - 4);
                drive($urandom_range(3, 0) != 0, int'(r), "");
            end
            drain();
        end

        check("R2 all results seen", exp_q.size(), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule